// File: doc/BRIEF.md
# Serial-In Shift Register with Latched Drive Outputs

This block is a chain of serial-in, parallel-out shift stages with a transparent storage latch behind every stage. A single serial bit enters the first stage on each rising clock edge, and every other stage takes the value of its neighbour. A level-sensitive store strobe copies the stages into the storage latches. While the strobe is low, the storage keeps its contents. The storage drives one low-side output driver per bit, gated by a global drive enable.

The outputs model open-drain pins. A drive-enable bit at 1 means the pin is actively pulled to ground. A 0 means the pin is released (high impedance). The pad data is always ground, so the per-bit enable vector is the only output that carries pin state.

Two serial outputs support chaining several blocks. One follows the last stage right after the rising edge, for chains with sharp clocks. The other re-times the same bit on the next falling edge. It is the one to feed the next block when the clock edges are slow.

Top module: `serial_latch_driver`

## Requirements
- R1: While `rst` is high at a rising edge, all shift stages clear. `ser_q2` clears on the next falling edge. The storage clears while `rst` is high. After reset, every `drv_en` bit is 0 and both serial outputs are 0.
- R2: On each rising `clk` edge, stage 0 takes `din` and stage k takes the old stage k-1. After STAGES bits are shifted in MSB first, stage k holds bit k of the pattern.
- R3: `ser_q1` equals the last stage (stage STAGES-1) and changes only after a rising edge.
- R4: `ser_q2` takes the value of `ser_q1` on each falling edge. Between a rising edge and the next falling edge, it still shows the bit from before that rising edge.
- R5: While `store_en` is high, storage bit k follows stage k, including through shifts.
- R6: While `store_en` is low, the storage keeps its value whatever is shifted in.
- R7: While `drv_oe` is low, every `drv_en` bit is 0 (all pins released).
- R8: While `drv_oe` is high, `drv_en[k]` is 1 exactly when storage bit k is 1.
- R9: Toggling `drv_oe` never changes the shift stages or the storage contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; stages move on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data into stage 0 |
| store_en | input | 1 | Level-sensitive storage strobe; high = transparent |
| drv_oe | input | 1 | Global drive enable for the parallel outputs |
| drv_en | output | STAGES | Per-pin pull-down enable (1 = pin pulled low, 0 = released) |
| ser_q1 | output | 1 | Last stage, updated on the rising edge |
| ser_q2 | output | 1 | Last stage, re-timed on the falling edge |

## Verification
Shifting and the transparent storage can act in the same cycle. When `store_en` is held high while bits keep arriving, the drive pins must ripple with every shift. When it drops, the pins must freeze on the last value seen. The bench mixes random runs, with `store_en` and `drv_oe` high in overlapping cycles, with directed MSB-first patterns, and checks the pins against a bench model after every edge. Two blocks are chained through `ser_q2`, so a 24-bit word lands split across both. `ser_q1` and `ser_q2` are sampled between the rising and falling edges, where they must differ by one bit position.

// File: rtl/sr_pkg.sv
package sr_pkg;

    // Default chain length of one block
    localparam int unsigned SR_DEF_STAGES = 12;

    // Control inputs grouped as one datapath word
    typedef struct packed {
        logic din;
        logic store_en;
        logic drv_oe;
    } sr_ctl_t;

    // Pin state of one open-drain output
    typedef enum logic {
        PIN_RELEASED = 1'b0,
        PIN_PULLED   = 1'b1
    } pin_state_e;

    // Pin state of one output from its storage bit and the global enable
    function automatic pin_state_e pin_state(input logic stored, input logic oe);
        return (stored && oe) ? PIN_PULLED : PIN_RELEASED;
    endfunction

endpackage

// File: rtl/sr_shift_chain.sv
module sr_shift_chain #(
    parameter int unsigned STAGES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    output logic [STAGES-1:0] stage
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else begin
            stage <= {stage[STAGES-2:0], din};
        end
    end

    // R2: each stage takes its lower neighbour, stage 0 takes the serial input
    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stage == {$past(stage[STAGES-2:0]), $past(din)}));

endmodule

// File: rtl/sr_store_latch.sv
module sr_store_latch #(
    parameter int unsigned STAGES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store_en,
    input  logic [STAGES-1:0] stage,
    output logic [STAGES-1:0] store
);

    // Transparent while store_en is high, holding while it is low
    always_latch begin
        if (rst) begin
            store <= '0;
        end else if (store_en) begin
            store <= stage;
        end
    end

    // R5: transparent storage tracks the stages
    p_follow_r5: assert property (@(posedge clk) disable iff (rst)
        store_en |-> (store == stage));

    // R6: closed storage keeps its value across edges
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!store_en && !$past(store_en) && !$past(rst)) |-> $stable(store));

endmodule

// File: rtl/sr_out_gate.sv
module sr_out_gate
    import sr_pkg::*;
#(
    parameter int unsigned STAGES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drv_oe,
    input  logic [STAGES-1:0] store,
    output logic [STAGES-1:0] drv_en
);

    for (genvar k = 0; k < STAGES; k++) begin : g_pin
        pin_state_e st;
        assign st        = pin_state(store[k], drv_oe);
        assign drv_en[k] = (st == PIN_PULLED);
    end

    // R7: disabled outputs are all released
    p_off_r7: assert property (@(posedge clk) disable iff (rst)
        !drv_oe |-> (drv_en == '0));

endmodule

// File: rtl/sr_cascade.sv
module sr_cascade (
    input  logic clk,
    input  logic rst,
    input  logic last_stage,
    output logic ser_q1,
    output logic ser_q2
);

    assign ser_q1 = last_stage;

    // Re-time on the falling edge for chains with slow clock edges
    always_ff @(negedge clk) begin
        if (rst) begin
            ser_q2 <= 1'b0;
        end else begin
            ser_q2 <= last_stage;
        end
    end

    // R4: just before each rising edge, the falling-edge copy matches the fast output
    p_retime_r4: assert property (@(posedge clk) disable iff (rst)
        ser_q2 == ser_q1);

endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
    import sr_pkg::*;
#(
    parameter int unsigned STAGES = SR_DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic              store_en,
    input  logic              drv_oe,
    output logic [STAGES-1:0] drv_en,
    output logic              ser_q1,
    output logic              ser_q2
);

    localparam int unsigned LAST = STAGES - 1;

    sr_ctl_t           ctl;
    logic [STAGES-1:0] stage;
    logic [STAGES-1:0] store;

    assign ctl = '{din: din, store_en: store_en, drv_oe: drv_oe};

    sr_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .din   (ctl.din),
        .stage (stage)
    );

    sr_store_latch #(.STAGES(STAGES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .store_en (ctl.store_en),
        .stage    (stage),
        .store    (store)
    );

    sr_out_gate #(.STAGES(STAGES)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .drv_oe (ctl.drv_oe),
        .store  (store),
        .drv_en (drv_en)
    );

    sr_cascade u_casc (
        .clk        (clk),
        .rst        (rst),
        .last_stage (stage[LAST]),
        .ser_q1     (ser_q1),
        .ser_q2     (ser_q2)
    );

endmodule

// File: tb/tb_serial_latch_driver.sv
`timescale 1ns/1ps
module tb_serial_latch_driver;

    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         din = 1'b0;
    logic         le  = 1'b0;
    logic         oe  = 1'b0;
    logic [N-1:0] drv_a, drv_b;
    logic         q1_a, q2_a, q1_b, q2_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model of both chained blocks
    logic [N-1:0] m_stg_a, m_stg_b, m_sto_a, m_sto_b;
    logic         m_q2_a, m_q2_b;

    always #2.5 clk = ~clk;

    serial_latch_driver #(.STAGES(N)) dut (
        .clk(clk), .rst(rst), .din(din), .store_en(le), .drv_oe(oe),
        .drv_en(drv_a), .ser_q1(q1_a), .ser_q2(q2_a)
    );

    serial_latch_driver #(.STAGES(N)) dut_b (
        .clk(clk), .rst(rst), .din(q2_a), .store_en(le), .drv_oe(oe),
        .drv_en(drv_b), .ser_q1(q1_b), .ser_q2(q2_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] pins(input logic [N-1:0] sto, input logic en);
        return en ? sto : '0;
    endfunction

    // one full clock cycle; called 0.5 ns after a falling edge
    task automatic cycle(input logic d, input logic l, input logic o);
        logic old_q2a;
        din = d; le = l; oe = o;
        if (l) begin m_sto_a = m_stg_a; m_sto_b = m_stg_b; end
        @(posedge clk); #0.5;
        old_q2a = m_q2_a;
        m_stg_b = {m_stg_b[N-2:0], m_q2_a};
        m_stg_a = {m_stg_a[N-2:0], d};
        if (l) begin m_sto_a = m_stg_a; m_sto_b = m_stg_b; end
        chk("R3 ser_q1 after rise", 32'(q1_a), 32'(m_stg_a[N-1]));
        chk("R4 ser_q2 before fall", 32'(q2_a), 32'(old_q2a));
        @(negedge clk); #0.5;
        m_q2_a = m_stg_a[N-1];
        m_q2_b = m_stg_b[N-1];
        chk("R4 ser_q2 after fall", 32'(q2_a), 32'(m_q2_a));
        chk("R4 chained ser_q2", 32'(q2_b), 32'(m_q2_b));
        chk(l ? "R5 pins A" : "R6 pins A", 32'(drv_a), 32'(pins(m_sto_a, o)));
        chk(o ? "R8 pins B" : "R7 pins B", 32'(drv_b), 32'(pins(m_sto_b, o)));
    endtask

    task automatic shift_word(input logic [N-1:0] w, input logic l, input logic o);
        for (int i = N - 1; i >= 0; i--) cycle(w[i], l, o);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        m_stg_a = '1; m_stg_b = '1; m_sto_a = '1; m_sto_b = '1;
        // fill with ones before reset so clearing is visible
        rst = 1'b0;
        @(negedge clk); #0.5;
        for (int i = 0; i < 2 * N + 2; i++) begin
            din = 1'b1; le = 1'b1; oe = 1'b1;
            @(negedge clk); #0.5;
        end
        // R1: reset
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin @(negedge clk); #0.5; end
        le = 1'b0;
        rst = 1'b0;
        m_stg_a = '0; m_stg_b = '0; m_sto_a = '0; m_sto_b = '0;
        m_q2_a = 1'b0; m_q2_b = 1'b0;
        chk("R1 pins A cleared", 32'(drv_a), 32'h0);
        chk("R1 pins B cleared", 32'(drv_b), 32'h0);
        chk("R1 ser_q1 cleared", 32'(q1_a), 32'h0);
        chk("R1 ser_q2 cleared", 32'(q2_a), 32'h0);

        // R2: MSB-first pattern with storage closed, then one strobe
        shift_word(12'hA5C, 1'b0, 1'b1);
        chk("R6 storage closed during shift", 32'(drv_a), 32'h0);
        cycle(1'b0, 1'b1, 1'b1);
        // after the strobe cycle the word is shifted by one
        chk("R2 pattern lands bit k in stage k", 32'(drv_a), 32'({12'hA5C, 1'b0} & 13'hFFF));

        // R9: toggle drive enable without shifting-sensitive change
        shift_word(12'h3C6, 1'b1, 1'b1);
        chk("R2 word in stage order", 32'(drv_a), 32'h3C6);
        le = 1'b0;
        for (int i = 0; i < 4; i++) begin
            oe = i[0];
            @(negedge clk); #0.5;
            chk("R7 R8 oe gate", 32'(drv_a), 32'(i[0] ? 12'h3C6 : 12'h000));
        end
        // shift state still intact: stages only moved by the idle cycles above
        // realign model: four idle cycles shifted din (last value) in
        for (int i = 0; i < 4; i++) begin
            m_stg_b = {m_stg_b[N-2:0], m_stg_a[N-1]};
            m_stg_a = {m_stg_a[N-2:0], din};
        end
        m_q2_a = m_stg_a[N-1]; m_q2_b = m_stg_b[N-1];
        cycle(1'b0, 1'b0, 1'b1);
        chk("R9 storage kept through oe toggles", 32'(drv_a), 32'h3C6);

        // two-block chain: 24-bit word splits across A (low) and B (high)
        shift_word(12'h9B1, 1'b0, 1'b1);
        shift_word(12'h64E, 1'b0, 1'b1);
        cycle(1'b0, 1'b1, 1'b0);
        chk("R7 pins off while strobing", 32'(drv_a | drv_b), 32'h0);
        cycle(1'b0, 1'b0, 1'b1);

        // random mix of shifting, strobing and drive enable
        for (int i = 0; i < 300; i++) begin
            cycle(1'($urandom_range(0, 1)), ($urandom_range(0, 9) < 3),
                  ($urandom_range(0, 9) < 6));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 act=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule